// File: doc/BRIEF.md
# Time-Slot Banked Register File

This block holds the architectural registers of an interleaved multithreaded core in which every clock cycle carries a slot number that advances modulo the slot count. Storage is split into one register file per slot, and each file is divided into one bank per hardware thread bound to that slot. Thread `t` belongs to slot `t mod NUM_SLOTS`, and its bank inside that file is `t / NUM_SLOTS`. Each file has two read ports and one write port. All banks of the file share these ports. A file is opened only on the cycle that carries its slot number, so two banks of one file never want the same port at once, and no arbitration or extra port is needed.

On each cycle the pipeline presents the current slot, the thread whose operands it decodes with two register addresses, and the writeback thread with an address, data and an enable. Reads are combinational, and a read that meets a same-cycle write to the same register of the same thread returns the new value. Writes take effect on the rising clock edge. A thread that is not bound to the slot presented is locked out. Its write is dropped and its reads return zero. Register 0 of every bank is hard-wired to zero. The block has no state machine: the slot schedule comes from outside, and the only sequential state is the register storage.

Top module: `tsb_regfile`

## Requirements
- R1: While `rst_n` is low, and after it returns high with no writes, every register of every thread reads as zero.
- R2: A write with `wr_en` high, a thread bound to `slot_id` and a nonzero address stores `wr_data`. From the following cycle onward a read of that thread and address returns it.
- R3: Register address 0 reads as zero on both ports for every thread, and writes to address 0 are dropped.
- R4: Threads that share a slot (thread IDs differing by a multiple of NUM_SLOTS) have separate banks. A write by one never changes what the other reads.
- R5: Threads bound to different slots have separate files. A write in one slot never changes what a thread of another slot reads.
- R6: When a read port addresses the nonzero register that the same thread writes in the same cycle, with the write effective under R2, that port returns `wr_data` in that cycle.
- R7: A write whose `wr_thread mod NUM_SLOTS` differs from `slot_id` is ignored, and all stored values stay unchanged.
- R8: When `rd_thread mod NUM_SLOTS` differs from `slot_id`, both read ports return zero.
- R9: The two read ports are independent. In one cycle each returns the value of its own address.
- R10: With `wr_en` low, no register changes, whatever the write address and data.
- R11: In any cycle, at most one register file takes a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset that clears all registers |
| slot_id | input | SLOT_W | Slot number of the current cycle |
| rd_thread | input | THR_W | Thread whose operands are read |
| rd_addr0 | input | ADDR_W | Register address for read port 0 |
| rd_addr1 | input | ADDR_W | Register address for read port 1 |
| rd_data0 | output | DATA_W | Read port 0 data (combinational) |
| rd_data1 | output | DATA_W | Read port 1 data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_thread | input | THR_W | Thread that writes back |
| wr_addr | input | ADDR_W | Register address written |
| wr_data | input | DATA_W | Data written |

## Verification
On every cycle, the assertions check the following:
- a stored write appears in its bank on the next cycle;
- an idle bank holds its contents;
- reads of an unbound thread and reads of register 0 return zero;
- same-cycle forwarding returns the write data;
- no more than one file reports a write.

Bank and file isolation cannot be shown by a local property. The same holds for a locked-out write leaving every register untouched, and for the full contents after reset. These rest on the bench's sweeps. The bench writes a distinct value into every register of every thread and then reads all of them back against an arithmetic model.

// File: rtl/tsb_pkg.sv
`timescale 1ns/1ps
package tsb_pkg;
    localparam int DEF_SLOTS   = 4;
    localparam int DEF_THREADS = 8;
    localparam int DEF_REGS    = 32;
    localparam int DEF_DATA_W  = 32;

    // width helper that never returns zero
    function automatic int safe_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/tsb_slot_decode.sv
`timescale 1ns/1ps
module tsb_slot_decode #(
    parameter int NUM_SLOTS = tsb_pkg::DEF_SLOTS,
    localparam int SLOT_W   = tsb_pkg::safe_w(NUM_SLOTS)
) (
    input  logic [SLOT_W-1:0]    slot_id,
    output logic [NUM_SLOTS-1:0] slot_en
);
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_dec
        assign slot_en[s] = (slot_id == SLOT_W'(s));
    end
endmodule

// File: rtl/tsb_bank.sv
`timescale 1ns/1ps
module tsb_bank #(
    parameter int NUM_REGS = tsb_pkg::DEF_REGS,
    parameter int DATA_W   = tsb_pkg::DEF_DATA_W,
    localparam int ADDR_W  = tsb_pkg::safe_w(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ra0,
    input  logic [ADDR_W-1:0] ra1,
    output logic [DATA_W-1:0] rd0,
    output logic [DATA_W-1:0] rd1,
    input  logic              we,
    input  logic [ADDR_W-1:0] wa,
    input  logic [DATA_W-1:0] wd
);
    logic [DATA_W-1:0] mem [NUM_REGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
        end else if (we && (wa != '0)) begin
            mem[wa] <= wd;
        end
    end

    always_comb begin
        rd0 = (ra0 == '0) ? '0 : mem[ra0];
        rd1 = (ra1 == '0) ? '0 : mem[ra1];
    end

    // R2: an accepted write is present in storage on the next cycle
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa != '0) |=> (mem[$past(wa)] == $past(wd)));

    // R10: an idle bank keeps the addressed word
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && $past(rst_n)) |=> (mem[$past(wa)] == $past(mem[wa])));
endmodule

// File: rtl/tsb_slot_file.sv
`timescale 1ns/1ps
module tsb_slot_file #(
    parameter int NUM_BANKS = tsb_pkg::DEF_THREADS / tsb_pkg::DEF_SLOTS,
    parameter int NUM_REGS  = tsb_pkg::DEF_REGS,
    parameter int DATA_W    = tsb_pkg::DEF_DATA_W,
    localparam int ADDR_W   = tsb_pkg::safe_w(NUM_REGS),
    localparam int BANK_W   = tsb_pkg::safe_w(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              file_en,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [ADDR_W-1:0] ra0,
    input  logic [ADDR_W-1:0] ra1,
    output logic [DATA_W-1:0] rd0,
    output logic [DATA_W-1:0] rd1,
    input  logic              wr_go,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [ADDR_W-1:0] wa,
    input  logic [DATA_W-1:0] wd,
    output logic              wr_hit
);
    logic [DATA_W-1:0]    b_rd0 [NUM_BANKS];
    logic [DATA_W-1:0]    b_rd1 [NUM_BANKS];
    logic [NUM_BANKS-1:0] b_we;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign b_we[b] = file_en && wr_go && (wr_bank == BANK_W'(b));
        tsb_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .ra0(ra0), .ra1(ra1), .rd0(b_rd0[b]), .rd1(b_rd1[b]),
            .we(b_we[b]), .wa(wa), .wd(wd)
        );
    end

    assign wr_hit = |b_we;

    // shared output bus: driven only while the file holds the slot
    always_comb begin
        rd0 = '0;
        rd1 = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (file_en && rd_bank == BANK_W'(b)) begin
                rd0 = b_rd0[b];
                rd1 = b_rd1[b];
            end
        end
    end

    // R4: one shared write port, so at most one bank written
    p_one_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(b_we));
endmodule

// File: rtl/tsb_regfile.sv
`timescale 1ns/1ps
module tsb_regfile #(
    parameter int NUM_SLOTS   = tsb_pkg::DEF_SLOTS,
    parameter int NUM_THREADS = tsb_pkg::DEF_THREADS,
    parameter int NUM_REGS    = tsb_pkg::DEF_REGS,
    parameter int DATA_W      = tsb_pkg::DEF_DATA_W,
    localparam int SLOT_W     = tsb_pkg::safe_w(NUM_SLOTS),
    localparam int THR_W      = tsb_pkg::safe_w(NUM_THREADS),
    localparam int ADDR_W     = tsb_pkg::safe_w(NUM_REGS),
    localparam int NUM_BANKS  = NUM_THREADS / NUM_SLOTS,
    localparam int BANK_W     = tsb_pkg::safe_w(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] slot_id,
    input  logic [THR_W-1:0]  rd_thread,
    input  logic [ADDR_W-1:0] rd_addr0,
    input  logic [ADDR_W-1:0] rd_addr1,
    output logic [DATA_W-1:0] rd_data0,
    output logic [DATA_W-1:0] rd_data1,
    input  logic              wr_en,
    input  logic [THR_W-1:0]  wr_thread,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    logic [NUM_SLOTS-1:0] slot_en;
    logic [NUM_SLOTS-1:0] file_wr_hit;
    logic [DATA_W-1:0]    f_rd0 [NUM_SLOTS];
    logic [DATA_W-1:0]    f_rd1 [NUM_SLOTS];
    logic                 rd_bound, wr_bound, wr_go;
    logic [BANK_W-1:0]    rd_bank, wr_bank;
    logic [DATA_W-1:0]    file_q0, file_q1;

    // thread t lives in slot t mod NUM_SLOTS, bank t / NUM_SLOTS
    assign rd_bound = (SLOT_W'(rd_thread % NUM_SLOTS) == slot_id);
    assign wr_bound = (SLOT_W'(wr_thread % NUM_SLOTS) == slot_id);
    assign rd_bank  = BANK_W'(rd_thread / NUM_SLOTS);
    assign wr_bank  = BANK_W'(wr_thread / NUM_SLOTS);
    assign wr_go    = wr_en && wr_bound;

    tsb_slot_decode #(.NUM_SLOTS(NUM_SLOTS)) u_dec (
        .slot_id(slot_id), .slot_en(slot_en)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_file
        tsb_slot_file #(
            .NUM_BANKS(NUM_BANKS), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W)
        ) u_file (
            .clk(clk), .rst_n(rst_n), .file_en(slot_en[s]),
            .rd_bank(rd_bank), .ra0(rd_addr0), .ra1(rd_addr1),
            .rd0(f_rd0[s]), .rd1(f_rd1[s]),
            .wr_go(wr_go), .wr_bank(wr_bank), .wa(wr_addr), .wd(wr_data),
            .wr_hit(file_wr_hit[s])
        );
    end

    always_comb begin
        file_q0 = '0;
        file_q1 = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (slot_en[s]) begin
                file_q0 = f_rd0[s];
                file_q1 = f_rd1[s];
            end
        end
    end

    // read mux with same-cycle write forwarding
    always_comb begin
        rd_data0 = '0;
        rd_data1 = '0;
        if (rd_bound) begin
            rd_data0 = file_q0;
            rd_data1 = file_q1;
            if (wr_go && wr_thread == rd_thread) begin
                if (rd_addr0 != '0 && rd_addr0 == wr_addr) rd_data0 = wr_data;
                if (rd_addr1 != '0 && rd_addr1 == wr_addr) rd_data1 = wr_data;
            end
        end
    end

    // R11: only the file owning the slot may take a write
    p_one_file_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(file_wr_hit));

    // R7: a file reporting a write must own the presented slot
    p_slot_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((file_wr_hit & ~slot_en) == '0));

    // R8: unbound reader sees zero on both ports
    p_unbound_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_bound |-> (rd_data0 == '0 && rd_data1 == '0));

    // R3: register 0 reads as zero
    p_zero_reg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr0 == '0) |-> (rd_data0 == '0));

    // R6: forwarding of a same-cycle write on port 0
    p_forward_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_bound && rd_bound && wr_thread == rd_thread &&
         rd_addr0 == wr_addr && wr_addr != '0) |-> (rd_data0 == wr_data));
endmodule

// File: tb/tsb_regfile_bench.sv
`timescale 1ns/1ps
module tsb_regfile_bench;
    localparam int C  = 4;
    localparam int T  = 8;
    localparam int R  = 32;
    localparam int W  = 32;
    localparam int SW = 2;
    localparam int TW = 3;
    localparam int AW = 5;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n;
    logic [SW-1:0] slot_id;
    logic [TW-1:0] rd_thread, wr_thread;
    logic [AW-1:0] rd_addr0, rd_addr1, wr_addr;
    logic [W-1:0]  rd_data0, rd_data1, wr_data;
    logic          wr_en;

    tsb_regfile u_tsb_regfile (
        .clk(clk), .rst_n(rst_n), .slot_id(slot_id),
        .rd_thread(rd_thread), .rd_addr0(rd_addr0), .rd_addr1(rd_addr1),
        .rd_data0(rd_data0), .rd_data1(rd_data1),
        .wr_en(wr_en), .wr_thread(wr_thread), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    logic [W-1:0] model [T][R];
    int total = 0;
    int bad   = 0;
    bit done  = 0;

    function automatic logic [W-1:0] pat(input int th, input int r, input int salt);
        return (32'h9E37_0000 ^ (th << 24)) + (r * 32'h0101) + salt * 32'h0010_0007;
    endfunction

    function automatic logic [W-1:0] exp_rd(input int slot, input int rth, input int ra,
                                            input bit we, input int wth, input int wa,
                                            input logic [W-1:0] wd);
        if (rth % C != slot) return '0;
        if (ra == 0) return '0;
        if (we && (wth % C == slot) && wth == rth && wa == ra) return wd;
        return model[rth][ra];
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input string req, input int slot, input int rth, input int ra0,
                        input int ra1, input bit we, input int wth, input int wa,
                        input logic [W-1:0] wd);
        @(negedge clk);
        slot_id = SW'(slot); rd_thread = TW'(rth);
        rd_addr0 = AW'(ra0); rd_addr1 = AW'(ra1);
        wr_en = we; wr_thread = TW'(wth); wr_addr = AW'(wa); wr_data = wd;
        #1;
        check(req, rd_data0, exp_rd(slot, rth, ra0, we, wth, wa, wd));
        check(req, rd_data1, exp_rd(slot, rth, ra1, we, wth, wa, wd));
        if (we && (wth % C == slot) && wa != 0) model[wth][wa] = wd;
    endtask

    task automatic read_all(input string req);
        for (int th = 0; th < T; th++)
            for (int r = 0; r < R; r++)
                step(req, th % C, th, r, R - 1 - r, 1'b0, 0, 0, '0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int th = 0; th < T; th++)
            for (int r = 0; r < R; r++) model[th][r] = '0;
        rst_n = 1'b0; slot_id = '0; rd_thread = '0; rd_addr0 = '0; rd_addr1 = '0;
        wr_en = 1'b0; wr_thread = '0; wr_addr = '0; wr_data = '0;
        // R1: outputs zero while held in reset
        @(negedge clk); rd_addr0 = 5'd9; rd_addr1 = 5'd31; #1;
        check("R1 in reset", rd_data0, '0);
        check("R1 in reset", rd_data1, '0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R1: every register zero after reset
        read_all("R1 cleared");

        // R2/R6/R3: sweep writes, port 0 forwards, port 1 reads old value
        for (int th = 0; th < T; th++)
            for (int r = 0; r < R; r++)
                step("R6 forward during sweep", th % C, th, r, (r + 1) % R, 1'b1, th, r, pat(th, r, 0));

        // R2/R3/R4/R5/R9: full readback of distinct values
        read_all("R2 R4 R5 R9 readback");

        // R6 on port 1, and R4: same-slot sibling thread must not forward
        step("R6 port1 forward", 2, 2, 4, 11, 1'b1, 2, 11, pat(2, 11, 5));
        step("R4 sibling no forward", 1, 5, 3, 3, 1'b1, 1, 3, pat(1, 3, 6));

        // R7: writes by threads not bound to the slot are dropped
        for (int th = 0; th < T; th++)
            step("R7 unbound write", (th + 1) % C, (th + 1) % C, 6, 7, 1'b1, th, 6, 32'hDEAD_BEEF);
        // R8: reads by threads not bound to the slot return zero
        for (int th = 0; th < T; th++)
            step("R8 unbound read", (th + 2) % C, th, 6, 12, 1'b0, 0, 0, '0);

        // R10: write enable low has no effect
        for (int th = 0; th < T; th++)
            step("R10 disabled write", th % C, th, 7, 8, 1'b0, th, 7, 32'h5555_AAAA);

        // R3: attempt to write register 0 for every thread
        for (int th = 0; th < T; th++)
            step("R3 write zero reg", th % C, th, 0, 0, 1'b1, th, 0, 32'hFFFF_FFFF);

        // second value pass then full readback
        for (int th = T - 1; th >= 0; th--)
            for (int r = 1; r < R; r += 3)
                step("R2 rewrite", th % C, th, r, 0, 1'b1, th, r, pat(th, r, 3));
        read_all("R2 R3 R4 R5 R7 R10 final");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule